// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and calendar date in packed BCD. It holds seconds, minutes, hours (24-hour), a weekday, day of month, month, a two-digit year, and a century bit that flips each time the year rolls over. A 64 Hz strobe, sampled as a clock enable in the single system clock domain, feeds a binary prescaler. The prescaler produces one second increment every full prescaler period. The seconds register also carries a flag that marks the stored time as untrustworthy after an oscillator failure.

Software loads any field through a one-cycle write strobe with an address and a data byte, and reads any field back through a combinational read port. A stop input freezes the chain and clears the prescaler. After stop is released, or after any write, the first second arrives after half a prescaler period, so test code can predict exactly when the next increment lands. Month lengths and leap years are worked out directly on the BCD values, so no binary conversion is needed. A field that holds an out-of-range or non-decimal value still returns to its first value, so the chain never locks up.

Address map used for both write and read: 0 seconds (bit 7 is the fail flag), 1 minutes, 2 hours, 3 weekday, 4 date, 5 month (bit 7 is the century bit), 6 year. Address 7 reads as 00.

Top module: `bcd_calendar_top`

## Requirements
- R1: Seconds (address 0, bits 6:0) and minutes (address 1) count 00 to 59 in BCD, with the low digit rolling 9 to 0 into the tens digit. Going from 59 to 00 increments the next field.
- R2: Hours (address 2) count 00 to 23. The step from 23 to 00 increments both the weekday and the date.
- R3: Weekday (address 3) counts 0 to 6 and then returns to 0.
- R4: Date (address 4) returns to 01 and increments the month after its last day. The last day is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11. For month 02 it is 29 when the BCD year is divisible by 4 (00 counts as such) and 28 otherwise.
- R5: Month (address 5, bits 4:0) counts 01 to 12 and returns to 01, incrementing the year. Year (address 6) counts 00 to 99 in BCD.
- R6: Bit 7 of address 5 is the century bit. It is loaded by a month write and inverts when the year steps from 99 to 00.
- R7: A second increment happens on the 2^(PRESC_W-1)-th strobe after a write or after stop is released. Each later increment happens 2^PRESC_W strobes after the one before it. Strobes need not arrive on consecutive cycles.
- R8: While stop is 1, no field changes on strobes.
- R9: Bit 7 of address 0 reads 1 after reset and becomes 1 in the cycle after osc_fail is 1. A write to address 0 with bit 7 = 0 clears it, and a write with bit 7 = 1 leaves it set.
- R10: A write loads the addressed field in the cycle of the write strobe, and the field then reads back the written value. Only the bits each field stores are kept.
- R11: A field holding a value at or above its last legal value returns to its first value on its next increment. A low digit of 9 or more steps the tens digit, so non-decimal codes never lock up the chain.
- R12: After reset the fields read seconds 80 (flag set), minutes 00, hours 00, weekday 00, date 01, month 01 (century 0) and year 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick64 | input | 1 | 64 Hz strobe, one cycle wide, used as a clock enable |
| stop | input | 1 | Freezes the chain and holds the prescaler at zero |
| osc_fail | input | 1 | Pulse that marks an oscillator failure |
| wr_en | input | 1 | Write strobe for one field |
| wr_addr | input | 3 | Field address for writes |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 3 | Field address for reads |
| rd_data | output | 8 | Combinational read data |

## Verification
The bench builds the block with PRESC_W = 3, so one second takes 8 strobes and the first second after a write takes 4. A state loaded one second before any rollover therefore reaches it within a few dozen cycles. This makes it practical to check the year-end and century wrap, every month-length class, leap and non-leap February, and illegal loaded codes, each from its own loaded state. With the same short prescaler, the exact strobe counts around a write and around stop release can be measured one strobe at a time.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int NUM_FIELDS = 7;

    // Field indices, also the register addresses.
    localparam int IDX_SEC   = 0;
    localparam int IDX_MIN   = 1;
    localparam int IDX_HOUR  = 2;
    localparam int IDX_WDAY  = 3;
    localparam int IDX_DATE  = 4;
    localparam int IDX_MONTH = 5;
    localparam int IDX_YEAR  = 6;

    typedef enum logic [2:0] {
        ADDR_SEC   = 3'd0,
        ADDR_MIN   = 3'd1,
        ADDR_HOUR  = 3'd2,
        ADDR_WDAY  = 3'd3,
        ADDR_DATE  = 3'd4,
        ADDR_MONTH = 3'd5,
        ADDR_YEAR  = 3'd6,
        ADDR_SPARE = 3'd7
    } reg_addr_e;

    // Stored bits per field.
    function automatic int field_width(input int idx);
        case (idx)
            IDX_SEC, IDX_MIN:   return 7;
            IDX_HOUR, IDX_DATE: return 6;
            IDX_WDAY:           return 3;
            IDX_MONTH:          return 5;
            default:            return 8;
        endcase
    endfunction

    // Value a field restarts at after its wrap.
    function automatic logic [7:0] field_first(input int idx);
        case (idx)
            IDX_DATE, IDX_MONTH: return 8'h01;
            default:             return 8'h00;
        endcase
    endfunction

    // Last legal value of a field (date is replaced at run time).
    function automatic logic [7:0] field_last(input int idx);
        case (idx)
            IDX_SEC, IDX_MIN: return 8'h59;
            IDX_HOUR:         return 8'h23;
            IDX_WDAY:         return 8'h06;
            IDX_DATE:         return 8'h31;
            IDX_MONTH:        return 8'h12;
            default:          return 8'h99;
        endcase
    endfunction

    // A BCD year is a multiple of four when an even tens digit meets
    // a units digit of 0/4/8, or an odd tens digit meets 2/6.
    function automatic logic is_leap_bcd(input logic [7:0] yr);
        if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        else        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] mo, input logic [7:0] yr);
        case (mo)
            8'h02:                      return is_leap_bcd(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // One BCD increment with wrap; any value at or past the limit restarts.
    function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] last,
                                            input logic [7:0] first);
        if (v >= last)              return first;
        else if (v[3:0] >= 4'd9)    return {v[7:4] + 4'd1, 4'd0};
        else                        return v + 8'd1;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int W = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic hold,
    input  logic clear,
    output logic tick
);
    localparam logic [W-1:0] HALF_M1 = W'((1 << (W - 1)) - 1);

    logic [W-1:0] cnt;

    // The second fires as the count crosses its midpoint, so a fresh
    // start from zero waits half a period and every later one a full period.
    assign tick = strobe && !hold && !clear && (cnt == HALF_M1);

    always_ff @(posedge clk) begin
        if (rst || hold || clear) begin
            cnt <= '0;
        end else if (strobe) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
    import rtc_cal_pkg::*;
#(
    parameter int         W     = 8,
    parameter logic [7:0] FIRST = 8'h00
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic [7:0]   last,
    output logic [W-1:0] value
);
    logic [7:0] wide;
    assign wide = 8'(value);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= W'(FIRST);
        end else if (load) begin
            value <= load_val;
        end else if (step) begin
            value <= W'(bcd_step(wide, last, FIRST));
        end
    end
endmodule

// File: rtl/bcd_calendar_top.sv
module bcd_calendar_top
    import rtc_cal_pkg::*;
#(
    parameter int PRESC_W = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick64,
    input  logic       stop,
    input  logic       osc_fail,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data
);
    logic                  sec_tick;
    logic [7:0]            fld  [NUM_FIELDS];
    logic [7:0]            last [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] step;
    logic                  c_sec, c_min, c_hour, c_date, c_month, c_year;
    logic                  century_q;
    logic                  fail_q;

    rtc_prescaler #(.W(PRESC_W)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .strobe (tick64),
        .hold   (stop),
        .clear  (wr_en),
        .tick   (sec_tick)
    );

    always_comb begin
        for (int i = 0; i < NUM_FIELDS; i++) begin
            last[i] = field_last(i);
        end
        last[IDX_DATE] = month_days(fld[IDX_MONTH], fld[IDX_YEAR]);
    end

    // Ripple of carries; each compares the registered field with its limit.
    assign c_sec   = sec_tick && (fld[IDX_SEC]   >= last[IDX_SEC]);
    assign c_min   = c_sec    && (fld[IDX_MIN]   >= last[IDX_MIN]);
    assign c_hour  = c_min    && (fld[IDX_HOUR]  >= last[IDX_HOUR]);
    assign c_date  = c_hour   && (fld[IDX_DATE]  >= last[IDX_DATE]);
    assign c_month = c_date   && (fld[IDX_MONTH] >= last[IDX_MONTH]);
    assign c_year  = c_month  && (fld[IDX_YEAR]  >= last[IDX_YEAR]);

    assign step = {c_month, c_date, c_hour, c_hour, c_min, c_sec, sec_tick};

    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
        localparam int FW = field_width(gi);
        logic [FW-1:0] q;
        rtc_bcd_field #(.W(FW), .FIRST(field_first(gi))) u_field (
            .clk      (clk),
            .rst      (rst),
            .load     (wr_en && (wr_addr == 3'(gi))),
            .load_val (wr_data[FW-1:0]),
            .step     (step[gi]),
            .last     (last[gi]),
            .value    (q)
        );
        assign fld[gi] = 8'(q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            century_q <= 1'b0;
            fail_q    <= 1'b1;
        end else begin
            if (wr_en && (wr_addr == ADDR_MONTH)) begin
                century_q <= wr_data[7];
            end else if (c_year) begin
                century_q <= ~century_q;
            end
            if (osc_fail) begin
                fail_q <= 1'b1;
            end else if (wr_en && (wr_addr == ADDR_SEC) && !wr_data[7]) begin
                fail_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_SEC:   rd_data = {fail_q, fld[IDX_SEC][6:0]};
            ADDR_MIN:   rd_data = fld[IDX_MIN];
            ADDR_HOUR:  rd_data = fld[IDX_HOUR];
            ADDR_WDAY:  rd_data = fld[IDX_WDAY];
            ADDR_DATE:  rd_data = fld[IDX_DATE];
            ADDR_MONTH: rd_data = {century_q, 2'b00, fld[IDX_MONTH][4:0]};
            ADDR_YEAR:  rd_data = fld[IDX_YEAR];
            default:    rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker (
    input logic       clk,
    input logic       rst,
    input logic       stop,
    input logic       wr_en,
    input logic       osc_fail,
    input logic       sec_tick,
    input logic       day_step,
    input logic       year_wrap,
    input logic [7:0] sec,
    input logic [7:0] mins,
    input logic [7:0] date,
    input logic [7:0] date_last,
    input logic [7:0] year,
    input logic       century,
    input logic       fail
);
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && sec >= 8'h59) |=> (sec == 8'h00)) else $error("sec wrap"); // R1

    AST_SEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && sec <= 8'h59) |=> (sec <= 8'h59)) else $error("sec range"); // R1

    AST_DATE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (day_step && date >= date_last) |=> (date == 8'h01)) else $error("date wrap"); // R4

    AST_CENTURY_FLIP: assert property (@(posedge clk) disable iff (rst)
        year_wrap |=> (century != $past(century))) else $error("century"); // R6

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (stop && !wr_en) |=> ($stable(sec) && $stable(mins) && $stable(date) && $stable(year)))
        else $error("stop"); // R8

    AST_FAIL_SET: assert property (@(posedge clk) disable iff (rst)
        osc_fail |=> fail) else $error("fail flag"); // R9
endmodule

bind bcd_calendar_top rtc_cal_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .stop      (stop),
    .wr_en     (wr_en),
    .osc_fail  (osc_fail),
    .sec_tick  (sec_tick),
    .day_step  (c_hour),
    .year_wrap (c_year),
    .sec       (fld[0]),
    .mins      (fld[1]),
    .date      (fld[4]),
    .date_last (last[4]),
    .year      (fld[6]),
    .century   (century_q),
    .fail      (fail_q)
);

// File: tb/bcd_calendar_top_tb.sv
module bcd_calendar_top_tb;
    localparam int PW   = 3;
    localparam int HALF = 1 << (PW - 1);
    localparam int FULL = 1 << PW;
    localparam int NV   = 19;

    // Each entry: loaded bytes for addresses 0..6, then expected bytes one second later.
    localparam logic [111:0] VEC [NV] = '{
        112'h12340502150621_13340502150621, // R1 plain step
        112'h09000000010100_10000000010100, // R1 units digit 9 into tens
        112'h59592306311299_00000000018100, // R2 R3 R5 R6 year end, century set
        112'h59592303280223_00000004010323, // R4 February, common year
        112'h59592303280224_00000004290224, // R4 February, leap year
        112'h59592304290224_00000005010324, // R4 leap day end
        112'h59592300280200_00000001290200, // R4 year 00 is leap
        112'h59592301300425_00000002010525, // R4 30-day month
        112'h59592301300125_00000002310125, // R4 31-day month reaches 31
        112'h59592302319299_00000003010100, // R6 century clears
        112'h59091105120730_00101105120730, // R1 minute carry
        112'h59590905120730_00001005120730, // R2 hour tens digit
        112'h7A300801050505_00310801050505, // R11 illegal seconds
        112'h59592F01050505_00000002060505, // R11 illegal hours
        112'h59592303280296_00000004290296, // R4 odd tens leap year
        112'h59592303280290_00000004010390, // R4 year 90 common
        112'h59592306311249_00000000010150, // R5 year tens digit
        112'h5959230631121A_00000000010120, // R11 illegal year digit
        112'h59592301350425_00000002010525  // R11 date past month end
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick64 = 1'b0;
    logic       stop = 1'b0;
    logic       osc_fail = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bcd_calendar_top #(.PRESC_W(PW)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .tick64   (tick64),
        .stop     (stop),
        .osc_fail (osc_fail),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe(input int n);
        repeat (n) begin
            @(negedge clk); tick64 = 1'b1;
            @(negedge clk); tick64 = 1'b0;
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired (all requirements)");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [111:0] vv;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 and R9: reset values
        rd(3'd0, v); check("R12 R9 reset seconds", v, 8'h80);
        rd(3'd1, v); check("R12 reset minutes", v, 8'h00);
        rd(3'd2, v); check("R12 reset hours", v, 8'h00);
        rd(3'd3, v); check("R12 reset weekday", v, 8'h00);
        rd(3'd4, v); check("R12 reset date", v, 8'h01);
        rd(3'd5, v); check("R12 reset month", v, 8'h01);
        rd(3'd6, v); check("R12 reset year", v, 8'h00);

        // Vector walk: R1 R2 R3 R4 R5 R6 R10 R11
        for (int vi = 0; vi < NV; vi++) begin
            vv = VEC[vi];
            for (int f = 0; f < 7; f++) begin
                wr(3'(f), vv[111 - 8 * f -: 8]);
            end
            strobe(HALF);
            for (int f = 0; f < 7; f++) begin
                rd(3'(f), v);
                check($sformatf("R1 R2 R3 R4 R5 R6 R10 R11 vector %0d addr %0d", vi, f),
                      v, vv[55 - 8 * f -: 8]);
            end
        end

        // R10 readback of a plain write
        wr(3'd1, 8'h42);
        rd(3'd1, v); check("R10 minute write readback", v, 8'h42);

        // R7 strobe counting after a write
        wr(3'd0, 8'h10);
        strobe(HALF - 1);
        rd(3'd0, v); check("R7 before first second", v, 8'h10);
        strobe(1);
        rd(3'd0, v); check("R7 first second after half period", v, 8'h11);
        strobe(FULL - 1);
        rd(3'd0, v); check("R7 before second increment", v, 8'h11);
        strobe(1);
        rd(3'd0, v); check("R7 full period increment", v, 8'h12);

        // R8 stop freezes, then R7 half period from release
        @(negedge clk); stop = 1'b1;
        strobe(3 * FULL);
        rd(3'd0, v); check("R8 seconds frozen", v, 8'h12);
        rd(3'd1, v); check("R8 minutes frozen", v, 8'h42);
        @(negedge clk); stop = 1'b0;
        strobe(HALF - 1);
        rd(3'd0, v); check("R7 R8 before first second after release", v, 8'h12);
        strobe(1);
        rd(3'd0, v); check("R7 R8 first second after release", v, 8'h13);

        // R9 fail flag
        @(negedge clk); osc_fail = 1'b1;
        @(negedge clk); osc_fail = 1'b0;
        rd(3'd0, v); check("R9 flag set by failure", v, 8'h93);
        wr(3'd0, 8'h85);
        rd(3'd0, v); check("R9 write with bit7 set keeps flag", v, 8'h85);
        wr(3'd0, 8'h05);
        rd(3'd0, v); check("R9 write with bit7 clear", v, 8'h05);

        // R11 and R3: illegal weekday restarts at 0 on the day step
        wr(3'd2, 8'h23);
        wr(3'd1, 8'h59);
        wr(3'd0, 8'h59);
        wr(3'd3, 8'h07);
        strobe(HALF);
        rd(3'd3, v); check("R11 R3 illegal weekday wraps", v, 8'h00);
        rd(3'd2, v); check("R2 hours wrap", v, 8'h00);

        // Spare address
        rd(3'd7, v); check("R10 spare address reads zero", v, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule